// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block is the standby controller of a core. On a stop request it halts the oscillator and the clocks. It holds them off until a reset request or a strong enough interrupt arrives. Each wake starts the oscillator again and then waits a fixed stabilization time. A 2-bit select input, captured when the wake happens, sets the length of that wait. The core clock stays gated for the whole wait.

When the wait ends, the block resumes in one of two ways. A reset-caused wake runs a short internal reset sequence with the clocks running, so the core comes up in reset state. An interrupt-caused wake gives a one-cycle resume pulse to the core's interrupt-acceptance logic. That logic then decides whether to branch to a handler or to continue after the stop instruction. A reset request wins over an interrupt if the two arrive together or if the reset comes during the wait.

Top module: `stop_wake_seq`

## Requirements
- R1: After rst_ni is released the block is running: osc_en_o=1, clk_en_o=1, core_rst_o=0 and resume_o=0.
- R2: A stop_req_i sampled while running turns off osc_en_o and clk_en_o from the next cycle. Both stay off until a wake.
- R3: While stopped, an interrupt wakes the block only if irq_valid_i=1 and irq_level_i<7. The level is 3 bits, a smaller value is stronger, and 7 means no request. Level 7, or irq_valid_i=0, leaves the block stopped.
- R4: A wake gives osc_en_o=1 with clk_en_o=0 for exactly 2^E cycles. E is 4, 10, 13 or 15 for wait_sel_i codes 00, 01, 10 and 11. The code is sampled in the wake cycle, and later changes have no effect.
- R5: After an interrupt wake's wait, resume_o is high for exactly one cycle with clk_en_o=1 and core_rst_o=0. The block then runs with resume_o low.
- R6: After a reset wake's wait, core_rst_o is high for exactly 4 cycles with both enables on. resume_o stays low throughout, and the block then runs with core_rst_o low.
- R7: A reset request arriving with an interrupt, or during the wait, makes the wake a reset wake. No resume pulse follows, and the wait is neither restarted nor lengthened.
- R8: stop_req_i is ignored during the wait, the reset sequence and the resume cycle.
- R9: While running, rst_req_i and interrupts have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (oscillator-domain) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_i | input | 1 | Request to enter stop mode |
| rst_req_i | input | 1 | Reset wake request |
| irq_valid_i | input | 1 | Interrupt request present |
| irq_level_i | input | 3 | Interrupt priority, 0 strongest, 7 none |
| wait_sel_i | input | 2 | Stabilization wait select |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | Core clock enable |
| core_rst_o | output | 1 | Internal reset to the core |
| resume_o | output | 1 | One-cycle interrupt-wake indication |

## Verification
The bench counts the gated-clock wait cycles for all four select codes. It also changes the select after the wake, so a design that samples it late gives a different length. It raises a reset request together with an interrupt and partway through the wait. A design that lets the interrupt win would pulse resume_o, and one that restarts the timer would stretch the wait. It also offers level-7 and invalid interrupts while stopped, and a design with an off-by-one threshold would wake on them. Finally it pokes stop requests and wake sources outside the stop state, where a careless design would re-enter stop or glitch core_rst_o.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP,
    ST_OSC_WAIT,
    ST_RESET_SEQ,
    ST_RESUME
  } wake_state_e;
endpackage

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int LVL_W = 3
) (
  input  logic             rst_req_i,
  input  logic             irq_valid_i,
  input  logic [LVL_W-1:0] irq_level_i,
  output logic             wake_o
);
  localparam logic [LVL_W-1:0] NoReqLvl = {LVL_W{1'b1}};

  logic irq_wake;
  assign irq_wake = irq_valid_i && (irq_level_i < NoReqLvl);
  assign wake_o   = rst_req_i || irq_wake;
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == limit_i);

  // wait length bound: counter never passes the programmed limit (R4)
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int EXP0    = 4,
  parameter int EXP1    = 10,
  parameter int EXP2    = 13,
  parameter int EXP3    = 15,
  parameter int RST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             rst_req_i,
  input  logic             irq_valid_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [1:0]       wait_sel_i,
  output logic             osc_en_o,
  output logic             clk_en_o,
  output logic             core_rst_o,
  output logic             resume_o
);
  localparam int MaxE01 = (EXP0 > EXP1) ? EXP0 : EXP1;
  localparam int MaxE23 = (EXP2 > EXP3) ? EXP2 : EXP3;
  localparam int MaxExp = (MaxE01 > MaxE23) ? MaxE01 : MaxE23;
  localparam int RstW   = $clog2(RST_LEN) + 1;
  localparam int CntW   = ((MaxExp > RstW) ? MaxExp : RstW) + 1;
  localparam logic [CntW-1:0] RstLimit = CntW'(RST_LEN - 1);
  localparam logic [LVL_W-1:0] NoReqLvl = {LVL_W{1'b1}};

  function automatic logic [CntW-1:0] sel_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   sel_limit = (CntW'(1) << EXP0) - 1'b1;
      2'b01:   sel_limit = (CntW'(1) << EXP1) - 1'b1;
      2'b10:   sel_limit = (CntW'(1) << EXP2) - 1'b1;
      default: sel_limit = (CntW'(1) << EXP3) - 1'b1;
    endcase
  endfunction

  wake_state_e     state_q, state_d;
  logic            wake;
  logic            rst_cause_q;
  logic [CntW-1:0] wait_lim_q;
  logic [CntW-1:0] tmr_limit;
  logic            tmr_done;
  logic            tmr_en;
  logic            tmr_clr;

  wake_filter #(.LVL_W(LVL_W)) u_filter (
    .rst_req_i  (rst_req_i),
    .irq_valid_i(irq_valid_i),
    .irq_level_i(irq_level_i),
    .wake_o     (wake)
  );

  assign tmr_en    = (state_q == ST_OSC_WAIT) || (state_q == ST_RESET_SEQ);
  assign tmr_clr   = (state_d != state_q);
  assign tmr_limit = (state_q == ST_RESET_SEQ) ? RstLimit : wait_lim_q;

  stab_timer #(.CNT_W(CntW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .limit_i(tmr_limit),
    .done_o (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (stop_req_i) state_d = ST_STOP;
      ST_STOP:      if (wake) state_d = ST_OSC_WAIT;
      ST_OSC_WAIT:  if (tmr_done)
                      state_d = (rst_cause_q || rst_req_i) ? ST_RESET_SEQ : ST_RESUME;
      ST_RESET_SEQ: if (tmr_done) state_d = ST_RUN;
      ST_RESUME:    state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      rst_cause_q <= 1'b0;
      wait_lim_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_STOP && wake) begin
        rst_cause_q <= rst_req_i;          // reset wins a tie
        wait_lim_q  <= sel_limit(wait_sel_i);
      end else if (state_q == ST_OSC_WAIT && rst_req_i) begin
        rst_cause_q <= 1'b1;               // late reset upgrades the wake
      end
    end
  end

  assign osc_en_o   = (state_q != ST_STOP);
  assign clk_en_o   = (state_q == ST_RUN) || (state_q == ST_RESET_SEQ) ||
                      (state_q == ST_RESUME);
  assign core_rst_o = (state_q == ST_RESET_SEQ);
  assign resume_o   = (state_q == ST_RESUME);

  p_stop_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i) |=> (!osc_en_o && !clk_en_o));

  p_no_false_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !rst_req_i && !(irq_valid_i && irq_level_i != NoReqLvl))
      |=> (state_q == ST_STOP));

  p_wake_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && wake) |=> (osc_en_o && !clk_en_o));

  p_resume_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> (!resume_o && clk_en_o));

  p_reset_no_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !resume_o);

  p_reset_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OSC_WAIT && rst_req_i) |=> !resume_o);

  p_stop_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && state_q != ST_STOP && stop_req_i) |=> (state_q != ST_STOP));

  p_run_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !stop_req_i) |=> (clk_en_o && !core_rst_o && !resume_o));
endmodule

// File: tb/sim_stop_wake_seq.sv
module sim_stop_wake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic       rst_req = 1'b0;
  logic       irq_valid = 1'b0;
  logic [2:0] irq_level = 3'd7;
  logic [1:0] wait_sel = 2'b00;
  logic       osc_en, clk_en, core_rst, resume;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  stop_wake_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .rst_req_i(rst_req),
    .irq_valid_i(irq_valid), .irq_level_i(irq_level), .wait_sel_i(wait_sel),
    .osc_en_o(osc_en), .clk_en_o(clk_en), .core_rst_o(core_rst), .resume_o(resume)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enter_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk("R2", "osc_en after stop", osc_en, 0);
    chk("R2", "clk_en after stop", clk_en, 0);
    repeat (3) @(negedge clk);
    chk("R2", "still stopped", osc_en, 0);
  endtask

  task automatic do_wake(input bit r, input bit v, input logic [2:0] lvl, input logic [1:0] sel);
    rst_req = r; irq_valid = v; irq_level = lvl; wait_sel = sel;
    @(negedge clk);
    rst_req = 1'b0; irq_valid = 1'b0; irq_level = 3'd7;
    wait_sel = ~sel;  // later select changes must not matter (R4)
    chk("R4", "osc_en in wait", osc_en, 1);
    chk("R4", "clk_en in wait", clk_en, 0);
  endtask

  task automatic wait_phase(input int rst_at, input int stop_at, output int n);
    n = 0;
    while (osc_en && !clk_en && n < 40000) begin
      rst_req  = (n == rst_at);
      stop_req = (n == stop_at);
      n++;
      @(negedge clk);
    end
    rst_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic finish_irq(input string req);
    chk(req, "resume pulse", resume, 1);
    chk(req, "clk_en at resume", clk_en, 1);
    chk(req, "core_rst at resume", core_rst, 0);
    @(negedge clk);
    chk(req, "resume dropped", resume, 0);
    chk(req, "running after resume", clk_en & osc_en, 1);
  endtask

  task automatic finish_rst(input string req, input bit stop_poke);
    int n = 0;
    int seen = 0;
    while (core_rst && n < 100) begin
      if (resume) seen = 1;
      if (!clk_en || !osc_en) seen = 2;
      stop_req = (stop_poke && n == 0);
      n++;
      @(negedge clk);
    end
    stop_req = 1'b0;
    chk(req, "reset sequence length", n, 4);
    chk(req, "no resume / clocks on in reset", seen, 0);
    chk(req, "core_rst released", core_rst, 0);
    chk(req, "running after reset", clk_en & osc_en, 1);
    chk(req, "no resume after reset", resume, 0);
  endtask

  task automatic t_reset();
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "clk_en", clk_en, 1);
    chk("R1", "core_rst", core_rst, 0);
    chk("R1", "resume", resume, 0);
  endtask

  task automatic t_run_ignored();
    @(negedge clk); rst_req = 1'b1; irq_valid = 1'b1; irq_level = 3'd0;
    @(negedge clk); rst_req = 1'b0; irq_valid = 1'b0; irq_level = 3'd7;
    for (int i = 0; i < 3; i++) begin
      chk("R9", "clk_en in run", clk_en, 1);
      chk("R9", "core_rst in run", core_rst, 0);
      chk("R9", "resume in run", resume, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_irq_filter();
    int n;
    enter_stop();
    irq_valid = 1'b1; irq_level = 3'd7;
    repeat (5) @(negedge clk);
    chk("R3", "level 7 no wake", osc_en, 0);
    irq_valid = 1'b0; irq_level = 3'd1;
    repeat (5) @(negedge clk);
    chk("R3", "invalid no wake", osc_en, 0);
    do_wake(1'b0, 1'b1, 3'd6, 2'b00);
    chk("R3", "level 6 wakes", osc_en, 1);
    wait_phase(-1, -1, n);
    chk("R4", "wait length sel 00", n, 16);
    finish_irq("R5");
  endtask

  task automatic t_irq_sel(input logic [1:0] sel, input int expn);
    int n;
    enter_stop();
    do_wake(1'b0, 1'b1, 3'd3, sel);
    wait_phase(-1, -1, n);
    chk("R4", "wait length", n, expn);
    finish_irq("R5");
  endtask

  task automatic t_rst_wake();
    int n;
    enter_stop();
    do_wake(1'b1, 1'b0, 3'd7, 2'b10);
    wait_phase(-1, -1, n);
    chk("R4", "wait length sel 10", n, 8192);
    finish_rst("R6", 1'b0);
  endtask

  task automatic t_simultaneous();
    int n;
    enter_stop();
    do_wake(1'b1, 1'b1, 3'd0, 2'b00);
    wait_phase(-1, -1, n);
    chk("R7", "tie wait length", n, 16);
    finish_rst("R7", 1'b0);
  endtask

  task automatic t_rst_in_wait();
    int n;
    enter_stop();
    do_wake(1'b0, 1'b1, 3'd2, 2'b01);
    wait_phase(500, -1, n);
    chk("R7", "wait not restarted", n, 1024);
    finish_rst("R7", 1'b0);
  endtask

  task automatic t_stop_ignored();
    int n;
    enter_stop();
    do_wake(1'b0, 1'b1, 3'd4, 2'b00);
    wait_phase(-1, 3, n);
    chk("R8", "stop in wait ignored", n, 16);
    chk("R8", "resume after poked wait", resume, 1);
    stop_req = 1'b1;  // poke during resume cycle
    @(negedge clk);
    stop_req = 1'b0;
    chk("R8", "stop in resume ignored", clk_en, 1);
    enter_stop();
    do_wake(1'b1, 1'b0, 3'd7, 2'b00);
    wait_phase(-1, -1, n);
    finish_rst("R8", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_ignored();
    t_irq_filter();
    t_irq_sel(2'b01, 1024);
    t_rst_wake();
    t_irq_sel(2'b11, 32768);
    t_simultaneous();
    t_rst_in_wait();
    t_stop_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule